// File: doc/BRIEF.md
# Flag-Offset Register Port with Cyclic Selection

This block holds the two thresholds that a dual-clock FIFO uses for its almost-empty and almost-full flags. Each threshold is split across two data-width registers (a low half and a high half), so four registers in all. They have no address. Software reaches them through the FIFO's own data ports while a shared, active-low load enable is held low. A programming write on the write clock stores the data input into the register that is currently selected. A programming read on the read clock copies the selected register onto a readback output. Each side keeps its own selection pointer. The pointer steps through the four registers in a fixed cycle and remembers its place while the load enable is released.

Whether the load enable serves as a programming control at all is decided during reset. If it is held low while reset is asserted, programming mode is on. Otherwise the load pin is ignored and every enabled access is passed on as a normal FIFO access. The joined and truncated thresholds go to the flag logic, which lies outside this block.

Top module: `flag_offset_port`

## Requirements
- R1: While reset is asserted and after it is released, both low-half registers hold the value LO_DEF (7) and both high-half registers hold 0. As a result, `empty_ofs` = `full_ofs` = 7 and `rb_data` = 0.
- R2: `prog_mode` is 1 after reset if and only if `ld_n` was low at the last write-clock edge during reset. `ld_n` may rise in the same instant as `rst_n`.
- R3: In programming mode, a write-clock edge with `ld_n`=0 and `wr_en_n`=0 stores `din` into the selected register and advances the selection. The selection order is: empty low (0), empty high (1), full low (2), full high (3).
- R4: In programming mode, `ld_n`=0 with `wr_en_n`=1 changes no register and gives `fifo_wr_req`=0.
- R5: In programming mode, `ld_n`=1 leaves every register unchanged. `fifo_wr_req` equals the inverse of `wr_en_n`.
- R6: After the full-high register, the next programming write wraps to the empty-low register.
- R7: Raising `ld_n` does not reset either selection pointer. The next programming access continues from where the sequence stopped.
- R8: In programming mode, a read-clock edge with `ld_n`=0 and `rd_en_n`=0 loads the selected register into `rb_data` and advances the read-side selection. This follows the same order as R3 and is independent of the write side. At any other read edge, `rb_data` holds its value.
- R9: When `prog_mode` is 0, `ld_n` has no effect. No register changes, `rb_data` holds its value, `fifo_wr_req` = inverse of `wr_en_n`, and `fifo_rd_req` = inverse of `rd_en_n`.
- R10: `empty_ofs` is {empty high, empty low} truncated to ADDR_W bits. `full_ofs` is formed in the same way from the full registers.
- R11: In programming mode, `fifo_rd_req` is 0 while `ld_n` is 0. It equals the inverse of `rd_en_n` while `ld_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset; mode is sampled while it is low |
| ld_n | input | 1 | Active-low load enable shared with the FIFO ports |
| wr_en_n | input | 1 | Active-low write enable |
| rd_en_n | input | 1 | Active-low read enable |
| din | input | WORD_W | FIFO data input, also the programming data |
| prog_mode | output | 1 | Programming mode latched at reset (write domain) |
| fifo_wr_req | output | 1 | Qualified normal FIFO write |
| fifo_rd_req | output | 1 | Qualified normal FIFO read |
| rb_data | output | WORD_W | Readback of the selected offset register |
| empty_ofs | output | ADDR_W | Almost-empty threshold |
| full_ofs | output | ADDR_W | Almost-full threshold |

## Verification
Suppose a selection pointer skips, sticks or resets when the load enable is released. The next programming write then lands in the wrong half. That shows up on `empty_ofs` or `full_ofs` at the very next write-clock edge. A read-side pointer error shows up on `rb_data` one read-clock edge after the faulty read. A wrong mode latch shows up at once on the request outputs, and also through offsets that either ignore writes or take them when they should not. The sweep writes varied values through several full wraps and compares the thresholds after every single write, so a misplaced register is caught within one access.

// File: rtl/fop_pkg.sv
package fop_pkg;

   localparam int NUM_OFS_REGS = 4;

   typedef enum logic [1:0] {
      SEL_E_LO = 2'd0,
      SEL_E_HI = 2'd1,
      SEL_F_LO = 2'd2,
      SEL_F_HI = 2'd3
   } ofs_sel_e;

   function automatic ofs_sel_e sel_next(input ofs_sel_e s);
      case (s)
         SEL_E_LO: return SEL_E_HI;
         SEL_E_HI: return SEL_F_LO;
         SEL_F_LO: return SEL_F_HI;
         default:  return SEL_E_LO;
      endcase
   endfunction

endpackage

// File: rtl/fop_mode_sample.sv
module fop_mode_sample (
   input  logic clk,
   input  logic rst_n,
   input  logic ld_n,
   output logic mode
);
   // Sampled on every edge while reset is low; the last in-reset edge wins,
   // so ld_n may be released together with rst_n.
   always_ff @(posedge clk) begin
      if (!rst_n) mode <= ~ld_n;
   end
endmodule

// File: rtl/fop_sel_ptr.sv
module fop_sel_ptr
   import fop_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     step,
   output ofs_sel_e sel
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    sel <= SEL_E_LO;
      else if (step) sel <= sel_next(sel);
   end
endmodule

// File: rtl/fop_reg_bank.sv
module fop_reg_bank
   import fop_pkg::*;
#(
   parameter int WORD_W = 9,
   parameter int LO_DEF = 7
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 we,
   input  ofs_sel_e                             sel,
   input  logic [WORD_W-1:0]                    din,
   output logic [NUM_OFS_REGS-1:0][WORD_W-1:0]  bank
);
   localparam logic [WORD_W-1:0] LO_RST = WORD_W'(LO_DEF);

   for (genvar g = 0; g < NUM_OFS_REGS; g++) begin : g_reg
      // even slots are low halves, odd slots high halves
      localparam logic [WORD_W-1:0] RST_V = (g % 2 == 0) ? LO_RST : '0;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                           bank[g] <= RST_V;
         else if (we && (int'(sel) == g))      bank[g] <= din;
      end
   end
endmodule

// File: rtl/fop_offset_join.sv
module fop_offset_join #(
   parameter int WORD_W = 9,
   parameter int ADDR_W = 17
) (
   input  logic [WORD_W-1:0] lo,
   input  logic [WORD_W-1:0] hi,
   output logic [ADDR_W-1:0] ofs
);
   if (ADDR_W > WORD_W) begin : g_wide
      assign ofs = {hi[ADDR_W-WORD_W-1:0], lo};
   end else begin : g_narrow
      logic unused_hi;
      assign unused_hi = ^hi;
      assign ofs = lo[ADDR_W-1:0];
   end
endmodule

// File: rtl/flag_offset_port.sv
module flag_offset_port
   import fop_pkg::*;
#(
   parameter int WORD_W = 9,
   parameter int ADDR_W = 17,
   parameter int LO_DEF = 7
) (
   input  logic              wr_clk,
   input  logic              rd_clk,
   input  logic              rst_n,
   input  logic              ld_n,
   input  logic              wr_en_n,
   input  logic              rd_en_n,
   input  logic [WORD_W-1:0] din,
   output logic              prog_mode,
   output logic              fifo_wr_req,
   output logic              fifo_rd_req,
   output logic [WORD_W-1:0] rb_data,
   output logic [ADDR_W-1:0] empty_ofs,
   output logic [ADDR_W-1:0] full_ofs
);
   localparam int THR_W = 2 * WORD_W;

   if (WORD_W < 1)         begin : g_chk_w  $error("WORD_W must be positive");              end
   if (ADDR_W < 1)         begin : g_chk_a  $error("ADDR_W must be positive");              end
   if (ADDR_W > THR_W)     begin : g_chk_aw $error("ADDR_W exceeds two register halves");   end
   if (LO_DEF < 0 || LO_DEF >= (1 << WORD_W))
                           begin : g_chk_d  $error("LO_DEF does not fit in WORD_W");        end

   logic mode_w, mode_r;
   logic wr_prog, rd_prog;
   ofs_sel_e sel_w, sel_r;
   logic [NUM_OFS_REGS-1:0][WORD_W-1:0] bank;

   fop_mode_sample u_mode_w (.clk(wr_clk), .rst_n(rst_n), .ld_n(ld_n), .mode(mode_w));
   fop_mode_sample u_mode_r (.clk(rd_clk), .rst_n(rst_n), .ld_n(ld_n), .mode(mode_r));

   assign wr_prog = mode_w & ~ld_n & ~wr_en_n;
   assign rd_prog = mode_r & ~ld_n & ~rd_en_n;

   fop_sel_ptr u_ptr_w (.clk(wr_clk), .rst_n(rst_n), .step(wr_prog), .sel(sel_w));
   fop_sel_ptr u_ptr_r (.clk(rd_clk), .rst_n(rst_n), .step(rd_prog), .sel(sel_r));

   fop_reg_bank #(.WORD_W(WORD_W), .LO_DEF(LO_DEF)) u_bank (
      .clk(wr_clk), .rst_n(rst_n), .we(wr_prog), .sel(sel_w), .din(din), .bank(bank)
   );

   // readback mux; a concurrent write to the same register gives undefined data
   always_ff @(posedge rd_clk or negedge rst_n) begin
      if (!rst_n)       rb_data <= '0;
      else if (rd_prog) rb_data <= bank[sel_r];
   end

   fop_offset_join #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_join_e (
      .lo(bank[SEL_E_LO]), .hi(bank[SEL_E_HI]), .ofs(empty_ofs)
   );
   fop_offset_join #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_join_f (
      .lo(bank[SEL_F_LO]), .hi(bank[SEL_F_HI]), .ofs(full_ofs)
   );

   assign prog_mode   = mode_w;
   assign fifo_wr_req = ~wr_en_n & ~(mode_w & ~ld_n);
   assign fifo_rd_req = ~rd_en_n & ~(mode_r & ~ld_n);
endmodule

// File: rtl/flag_offset_port_chk.sv
module flag_offset_port_chk #(
   parameter int WORD_W = 9,
   parameter int ADDR_W = 17
) (
   input logic              wr_clk,
   input logic              rd_clk,
   input logic              rst_n,
   input logic              ld_n,
   input logic              wr_en_n,
   input logic              rd_en_n,
   input logic              prog_mode,
   input logic              fifo_wr_req,
   input logic [WORD_W-1:0] rb_data,
   input logic [ADDR_W-1:0] empty_ofs,
   input logic [ADDR_W-1:0] full_ofs
);
   // R4: load low without write enable leaves the thresholds alone
   a_r4_idle_hold: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (prog_mode && !ld_n && wr_en_n) |=> ($stable(empty_ofs) && $stable(full_ofs)));

   // R4: a programming access is never passed on as a FIFO write
   a_r4_no_fifo_wr: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (prog_mode && !ld_n) |-> !fifo_wr_req);

   // R5: load released, registers untouched
   a_r5_fifo_path_hold: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (prog_mode && ld_n) |=> ($stable(empty_ofs) && $stable(full_ofs)));

   // R9: outside programming mode the thresholds never move
   a_r9_no_prog_hold: assert property (@(posedge wr_clk) disable iff (!rst_n)
      !prog_mode |=> ($stable(empty_ofs) && $stable(full_ofs)));

   // R8: readback only changes on a programming read
   a_r8_rb_hold: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (ld_n || rd_en_n) |=> $stable(rb_data));
endmodule

bind flag_offset_port flag_offset_port_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (
   .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .ld_n(ld_n),
   .wr_en_n(wr_en_n), .rd_en_n(rd_en_n), .prog_mode(prog_mode),
   .fifo_wr_req(fifo_wr_req), .rb_data(rb_data),
   .empty_ofs(empty_ofs), .full_ofs(full_ofs)
);

// File: tb/flag_offset_port_tb_top.sv
`timescale 1ns/1ps
module flag_offset_port_tb_top;
   localparam int WW = 4;
   localparam int AW = 6;

   logic wr_clk = 0, rd_clk = 0;
   logic rst_n = 0, ld_n = 0, wr_en_n = 1, rd_en_n = 1;
   logic [WW-1:0] din = '0;
   logic prog_mode, fifo_wr_req, fifo_rd_req;
   logic [WW-1:0] rb_data;
   logic [AW-1:0] empty_ofs, full_ofs;

   int n_run = 0, n_fail = 0;
   int mreg [4];
   int wp = 0, rp = 0;
   logic wreq_s, rreq_s;
   bit done = 0;

   always #2.5 wr_clk = ~wr_clk;
   initial begin #1.25; forever #2.5 rd_clk = ~rd_clk; end

   flag_offset_port #(.WORD_W(WW), .ADDR_W(AW), .LO_DEF(7)) dut_i (
      .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .ld_n(ld_n),
      .wr_en_n(wr_en_n), .rd_en_n(rd_en_n), .din(din),
      .prog_mode(prog_mode), .fifo_wr_req(fifo_wr_req), .fifo_rd_req(fifo_rd_req),
      .rb_data(rb_data), .empty_ofs(empty_ofs), .full_ofs(full_ofs)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int joinv(input int hi, input int lo);
      return ((hi << WW) | lo) & ((1 << AW) - 1);
   endfunction

   task automatic chk_ofs(input string req);
      chk({req, " empty_ofs"}, int'(empty_ofs), joinv(mreg[1], mreg[0]));
      chk({req, " full_ofs"},  int'(full_ofs),  joinv(mreg[3], mreg[2]));
   endtask

   // apply inputs for exactly one edge of each clock; called at a wr_clk negedge
   task automatic step(input logic l, input logic we, input logic re, input int d);
      ld_n = l; wr_en_n = we; rd_en_n = re; din = WW'(d);
      #1;
      wreq_s = fifo_wr_req; rreq_s = fifo_rd_req;
      @(negedge wr_clk);
   endtask

   task automatic do_reset(input logic ld_during);
      @(negedge wr_clk);
      rst_n = 0; ld_n = ld_during; wr_en_n = 1; rd_en_n = 1;
      repeat (3) @(negedge wr_clk);
      rst_n = 1; ld_n = 1;
      @(negedge wr_clk);
      mreg[0] = 7; mreg[1] = 0; mreg[2] = 7; mreg[3] = 0; wp = 0; rp = 0;
   endtask

   task automatic pwrite(input int v, input string req);
      step(0, 0, 1, v);
      mreg[wp] = v; wp = (wp + 1) % 4;
      chk_ofs(req);
   endtask

   task automatic pread(input string req);
      int e;
      e = mreg[rp];
      step(0, 1, 0, 0);
      rp = (rp + 1) % 4;
      chk({req, " rb_data"}, int'(rb_data), e);
      chk("R11 prog read not forwarded", int'(rreq_s), 0);
   endtask

   initial begin
      // reset check while asserted (R1)
      #1;
      chk("R1 rb_data in reset", int'(rb_data), 0);
      do_reset(0);
      chk("R2 prog_mode with ld low", int'(prog_mode), 1);
      chk("R1 empty_ofs default", int'(empty_ofs), 7);
      chk("R1 full_ofs default", int'(full_ofs), 7);
      chk("R1 rb_data default", int'(rb_data), 0);

      // sequencing, idle, release and wrap
      pwrite(5, "R3 write elo");
      pwrite(2, "R3 write ehi");
      step(0, 1, 1, 9);
      chk("R4 fifo_wr_req idle", int'(wreq_s), 0);
      chk_ofs("R4 idle no change");
      step(1, 0, 1, 11);
      chk("R5 fifo_wr_req", int'(wreq_s), 1);
      chk_ofs("R5 no change on fifo write");
      step(1, 1, 1, 12);
      chk("R5 both high no req", int'(wreq_s), 0);
      pwrite(9, "R7 continue at flo after release");
      pwrite(3, "R3 write fhi");
      pwrite(14, "R6 wrap to elo");
      pwrite(1, "R6 second pass ehi");
      chk("R10 joined empty", int'(empty_ofs), (1 << 4) | 14);

      // readback (R8, R11)
      pread("R8 read elo");
      pread("R8 read ehi");
      step(1, 1, 0, 0);
      chk("R11 fifo_rd_req when ld high", int'(rreq_s), 1);
      chk("R8 rb_data holds", int'(rb_data), mreg[1]);
      pread("R7 read continues flo");
      pread("R8 read fhi");
      pread("R8 read wraps elo");

      // sweep through many wraps
      for (int v = 0; v < 16; v++) begin
         pwrite(v, "R3 sweep");
         pwrite(v ^ 5, "R3 sweep");
         pwrite(15 - v, "R10 sweep");
         pwrite((v + 1) & 15, "R6 sweep");
      end
      for (int k = 0; k < 8; k++) pread("R8 sweep read");

      // non-programming mode (R2, R9)
      do_reset(1);
      chk("R2 prog_mode with ld high", int'(prog_mode), 0);
      for (int k = 0; k < 3; k++) begin
         step(0, 0, 1, 9 + k);
         chk("R9 fifo_wr_req with ld low", int'(wreq_s), 1);
         chk_ofs("R9 offsets unchanged");
      end
      step(0, 1, 0, 0);
      chk("R9 fifo_rd_req with ld low", int'(rreq_s), 1);
      chk("R9 rb_data unchanged", int'(rb_data), 0);

      // ld_n released together with reset (R2)
      do_reset(0);
      chk("R2 zero-hold mode", int'(prog_mode), 1);
      pwrite(6, "R3 after tied reset");

      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      #200000;
      if (!done) begin
         done = 1;
         n_run++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule